// File: doc/BRIEF.md
# Conditional Data-Processing Unit with Status Flags

This block is the integer data-processing stage of a load/store RISC core. Each strobed operation brings two 32-bit operands, a 4-bit opcode, a set-flags bit, a 4-bit condition code and the current status flags. It then yields a result, a result write-enable, the next flag value and a flag write-enable. The operations are add, subtract and reverse subtract (with and without carry), bitwise logic, move, and four compare/test operations that touch only the flags. Before anything is written, every operation is gated by a condition evaluated on the incoming flags.

The operand shifter lives outside the block. It passes in its carry-out and a bit that says whether a shift was actually applied. The result is formed combinationally. A two-state output controller (`ST_IDLE`, `ST_VALID`) registers it, so the outputs are valid exactly one cycle after the input strobe. The transitions are: `ST_IDLE -> ST_VALID` on a strobe, `ST_VALID -> ST_VALID` on a back-to-back strobe, `ST_VALID -> ST_IDLE` when no strobe arrives, and `ST_IDLE -> ST_IDLE` otherwise. In `ST_IDLE` both write-enables are low and the result and flag registers hold.

Top module: `cond_alu`

## Requirements
- R1: Opcode encoding 2 SUB (a-b), 3 RSB (b-a), 4 ADD (a+b), 5 ADC (a+b+C), 6 SBC (a-b-!C) and 7 RSC (b-a-!C) give the stated 32-bit result.
- R2: Opcode encoding 0 AND, 1 EOR, 12 ORR, 13 MOV (b), 14 BIC (a AND NOT b) and 15 MVN (NOT b) give the stated 32-bit result.
- R3: Opcodes 8 TST (AND), 9 TEQ (EOR), 10 CMP (a-b) and 11 CMN (a+b) never assert result_we, and they write the flags whenever their condition passes, whatever set_flags is.
- R4: All other opcodes assert flags_we only when set_flags is 1 and the condition passes.
- R5: The flag vector is ordered {N,Z,C,V} from bit 3 to bit 0. Arithmetic opcodes (2..7, 10, 11) set N from result bit 31 and Z when the result is zero. They set C to the adder carry-out, which for subtraction means no borrow (C=1 when the minuend is not below subtrahend plus borrow, unsigned). They set V on signed overflow.
- R6: Logic and move opcodes (0, 1, 8, 9, 12..15) set N and Z from the result and keep V. C takes shift_carry when shift_used is 1 and keeps its old value otherwise.
- R7: Condition encoding: 0 EQ (Z), 1 NE, 2 CS/HS (C), 3 CC/LO, 4 MI (N), 5 PL, 6 VS (V), 7 VC, 8 HI (C and not Z), 9 LS, 10 GE (N==V), 11 LT, 12 GT (not Z and N==V), 13 LE and 14 AL (always).
- R8: When the condition fails, result_we and flags_we are both 0 and flags_out equals the incoming flags_in.
- R9: Condition code 15 never passes.
- R10: After reset all outputs are 0. out_valid, result, result_we, flags_out and flags_we reflect the operation strobed on the previous cycle. When no strobe came, out_valid, result_we and flags_we are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Request flag update for non-test opcodes |
| cond | input | 4 | Condition code |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (shifter output) |
| flags_in | input | 4 | Current {N,Z,C,V} |
| shift_carry | input | 1 | Shifter carry-out |
| shift_used | input | 1 | Shifter applied a shift |
| out_valid | output | 1 | Outputs hold a new operation |
| result | output | 32 | Operation result |
| result_we | output | 1 | Write result to destination |
| flags_out | output | 4 | Next {N,Z,C,V} |
| flags_we | output | 1 | Write flags |

## Verification
The bench goes after the flag corners that are easy to get wrong. The first is carry for subtraction: a design that treats C as borrow inverts CS/CC decisions after every compare. Next are signed overflow across 0x7FFFFFFF and 0x80000000, and the borrow-in of SBC and RSC, which is off by one if the carry is used directly. It checks that logic operations keep V and pick C from the shifter only when a shift happened; a design that clears them breaks carry chains. It sweeps every condition code against several flag patterns, including code 15, and checks that a failing condition writes neither result nor flags. It also checks that compares write no register, since a design that let them write would corrupt the destination.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } out_state_e;

    function automatic logic op_is_test(input logic [3:0] op);
        return op[3:2] == 2'b10;
    endfunction

    function automatic logic op_is_arith(input logic [3:0] op);
        return (op >= 4'd2 && op <= 4'd7) || op == 4'd10 || op == 4'd11;
    endfunction

endpackage

// File: rtl/cond_alu_cond.sv
module cond_alu_cond
    import cond_alu_pkg::*;
(
    input  nzcv_t      flags_i,
    input  logic [3:0] cond_i,
    output logic       pass_o
);

    logic base;

    // Even codes test a predicate, odd codes its inverse; 14/15 form AL/NV.
    always_comb begin
        unique case (cond_i[3:1])
            3'd0: base = flags_i.z;
            3'd1: base = flags_i.c;
            3'd2: base = flags_i.n;
            3'd3: base = flags_i.v;
            3'd4: base = flags_i.c & ~flags_i.z;
            3'd5: base = (flags_i.n == flags_i.v);
            3'd6: base = ~flags_i.z & (flags_i.n == flags_i.v);
            default: base = 1'b1;
        endcase
    end

    assign pass_o = base ^ cond_i[0];

endmodule

// File: rtl/cond_alu_arith.sv
module cond_alu_arith
    import cond_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   op_i,
    input  logic         c_i,
    output logic [W-1:0] sum_o,
    output logic         c_o,
    output logic         v_o
);

    localparam int MSB = W - 1;

    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         cin;
    logic [W:0]   full;

    always_comb begin
        x   = a_i;
        y   = b_i;
        cin = 1'b0;
        unique case (alu_op_e'(op_i))
            OP_ADD, OP_CMN: cin = 1'b0;
            OP_ADC:         cin = c_i;
            OP_SUB, OP_CMP: begin y = ~b_i; cin = 1'b1; end
            OP_SBC:         begin y = ~b_i; cin = c_i;  end
            OP_RSB:         begin x = b_i; y = ~a_i; cin = 1'b1; end
            OP_RSC:         begin x = b_i; y = ~a_i; cin = c_i;  end
            default:        cin = 1'b0;
        endcase
    end

    assign full  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    assign sum_o = full[MSB:0];
    assign c_o   = full[W];
    assign v_o   = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);

endmodule

// File: rtl/cond_alu_logic.sv
module cond_alu_logic
    import cond_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   op_i,
    output logic [W-1:0] res_o
);

    always_comb begin
        unique case (alu_op_e'(op_i))
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_MOV:         res_o = b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = '0;
        endcase
    end

endmodule

// File: rtl/cond_alu.sv
module cond_alu
    import cond_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [3:0]   opcode,
    input  logic         set_flags,
    input  logic [3:0]   cond,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   flags_in,
    input  logic         shift_carry,
    input  logic         shift_used,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         result_we,
    output logic [3:0]   flags_out,
    output logic         flags_we
);

    localparam int MSB = W - 1;

    nzcv_t        fl_cur;
    nzcv_t        fl_calc;
    nzcv_t        fl_next;
    logic         cond_pass;
    logic [W-1:0] arith_res;
    logic         arith_c;
    logic         arith_v;
    logic [W-1:0] logic_res;
    logic [W-1:0] res_sel;
    logic         is_arith;
    logic         is_test;
    logic         wr_res;
    logic         wr_fl;

    out_state_e   state_q;
    out_state_e   state_d;

    assign fl_cur = nzcv_t'(flags_in);

    cond_alu_cond u_cond (
        .flags_i (fl_cur),
        .cond_i  (cond),
        .pass_o  (cond_pass)
    );

    cond_alu_arith #(.W(W)) u_arith (
        .a_i   (op_a),
        .b_i   (op_b),
        .op_i  (opcode),
        .c_i   (fl_cur.c),
        .sum_o (arith_res),
        .c_o   (arith_c),
        .v_o   (arith_v)
    );

    cond_alu_logic #(.W(W)) u_logic (
        .a_i   (op_a),
        .b_i   (op_b),
        .op_i  (opcode),
        .res_o (logic_res)
    );

    assign is_arith = op_is_arith(opcode);
    assign is_test  = op_is_test(opcode);
    assign res_sel  = is_arith ? arith_res : logic_res;
    assign wr_res   = cond_pass & ~is_test;
    assign wr_fl    = cond_pass & (is_test | set_flags);

    always_comb begin
        fl_calc.n = res_sel[MSB];
        fl_calc.z = (res_sel == '0);
        if (is_arith) begin
            fl_calc.c = arith_c;
            fl_calc.v = arith_v;
        end else begin
            fl_calc.c = shift_used ? shift_carry : fl_cur.c;
            fl_calc.v = fl_cur.v;
        end
        fl_next = wr_fl ? fl_calc : fl_cur;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            result_we <= 1'b0;
            flags_out <= '0;
            flags_we  <= 1'b0;
        end else if (in_valid) begin
            result    <= res_sel;
            result_we <= wr_res;
            flags_out <= fl_next;
            flags_we  <= wr_fl;
        end else begin
            result_we <= 1'b0;
            flags_we  <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_VALID);

endmodule

// File: rtl/cond_alu_checker.sv
module cond_alu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  opcode,
    input logic        set_flags,
    input logic [3:0]  cond,
    input logic [3:0]  flags_in,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        result_we,
    input logic [3:0]  flags_out,
    input logic        flags_we
);

    assert_strobe_to_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_has_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!result_we && !flags_we));

    assert_test_no_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(opcode[3:2]) == 2'b10) |-> !result_we);

    assert_s_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(set_flags) && $past(opcode[3:2]) != 2'b10) |-> !flags_we);

    assert_never_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cond) == 4'hF) |-> (!result_we && !flags_we));

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !flags_we) |-> flags_out == $past(flags_in));

    assert_logic_keeps_v_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_we &&
         ($past(opcode) inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15}))
        |-> flags_out[0] == $past(flags_in[0]));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result_we && flags_we) |-> flags_out[2] == (result == 32'd0));

endmodule

bind cond_alu cond_alu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .set_flags (set_flags),
    .cond      (cond),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .result_we (result_we),
    .flags_out (flags_out),
    .flags_we  (flags_we)
);

// File: tb/sim_cond_alu.sv
`timescale 1ns/1ps
module sim_cond_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic        set_flags = 1'b0;
    logic [3:0]  cond = 4'd14;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  flags_in = '0;
    logic        shift_carry = 1'b0;
    logic        shift_used = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  flags_out;
    logic        flags_we;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cond_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .set_flags(set_flags), .cond(cond), .op_a(op_a), .op_b(op_b),
        .flags_in(flags_in), .shift_carry(shift_carry), .shift_used(shift_used),
        .out_valid(out_valid), .result(result), .result_we(result_we),
        .flags_out(flags_out), .flags_we(flags_we)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Condition truth from the R7 table, flags {N,Z,C,V}
    function automatic bit ref_cond(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cf = f[1], v = f[0];
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cf;
            4'd3:  return !cf;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cf && !z;
            4'd9:  return !cf || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Returns {result_we, flags_we, flags[3:0], result[31:0]}
    function automatic logic [37:0] ref_model(input logic [3:0] op, input bit s, input logic [3:0] c,
                                              input logic [31:0] a, input logic [31:0] b,
                                              input logic [3:0] f, input bit sc, input bit su);
        logic [31:0] r, m, sb;
        logic [32:0] t;
        bit nc, nv, arith, sub, bw, test, pass, rwe, fwe;
        logic [3:0] nf;
        r = '0; nc = f[1]; nv = f[0]; arith = 1'b1; sub = 1'b0; bw = 1'b0; m = a; sb = b;
        case (op)
            4'd4, 4'd11: begin t = {1'b0, a} + {1'b0, b}; r = t[31:0]; nc = t[32];
                               nv = (a[31] == b[31]) && (r[31] != a[31]); end
            4'd5: begin t = {1'b0, a} + {1'b0, b} + {32'd0, f[1]}; r = t[31:0]; nc = t[32];
                        nv = (a[31] == b[31]) && (r[31] != a[31]); end
            4'd2, 4'd10: begin sub = 1'b1; end
            4'd6: begin sub = 1'b1; bw = !f[1]; end
            4'd3: begin sub = 1'b1; m = b; sb = a; end
            4'd7: begin sub = 1'b1; m = b; sb = a; bw = !f[1]; end
            default: arith = 1'b0;
        endcase
        if (sub) begin
            r  = m - sb - {31'd0, bw};
            nc = ({1'b0, m} >= ({1'b0, sb} + {32'd0, bw}));
            nv = (m[31] != sb[31]) && (r[31] != m[31]);
        end
        if (!arith) begin
            case (op)
                4'd0, 4'd8:  r = a & b;
                4'd1, 4'd9:  r = a ^ b;
                4'd12:       r = a | b;
                4'd13:       r = b;
                4'd14:       r = a & ~b;
                default:     r = ~b;
            endcase
            nc = su ? sc : f[1];
            nv = f[0];
        end
        test = (op >= 4'd8 && op <= 4'd11);
        pass = ref_cond(c, f);
        rwe  = pass && !test;
        fwe  = pass && (test || s);
        nf   = fwe ? {r[31], r == 32'd0, nc, nv} : f;
        return {rwe, fwe, nf, r};
    endfunction

    // Drive one strobe, check outputs one cycle later
    task automatic run_op(input logic [3:0] op, input bit s, input logic [3:0] c,
                          input logic [31:0] a, input logic [31:0] b, input logic [3:0] f,
                          input bit sc, input bit su, input string req);
        logic [37:0] e;
        e = ref_model(op, s, c, a, b, f, sc, su);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; set_flags = s; cond = c;
        op_a = a; op_b = b; flags_in = f; shift_carry = sc; shift_used = su;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, {req, " valid"}, {31'd0, out_valid}, 32'd1);
        chk(result_we === e[37], {req, " result_we"}, {31'd0, result_we}, {31'd0, e[37]});
        chk(flags_we === e[36], {req, " flags_we"}, {31'd0, flags_we}, {31'd0, e[36]});
        chk(flags_out === e[35:32], {req, " flags"}, {28'd0, flags_out}, {28'd0, e[35:32]});
        if (e[37] || e[36])
            chk(result === e[31:0], {req, " result"}, result, e[31:0]);
    endtask

    task automatic test_reset();
        chk(out_valid === 1'b0 && result_we === 1'b0 && flags_we === 1'b0,
            "R10 reset enables", {29'd0, out_valid, result_we, flags_we}, 32'd0);
        chk(result === 32'd0 && flags_out === 4'd0, "R10 reset data", result, 32'd0);
    endtask

    task automatic test_arith();
        run_op(4'd4, 1, 4'd14, 32'd5, 32'd7, 4'h0, 0, 0, "R1 ADD");
        chk(result === 32'd12, "R1 ADD literal", result, 32'd12);
        run_op(4'd4, 1, 4'd14, 32'h7FFFFFFF, 32'd1, 4'h0, 0, 0, "R5 ADD overflow");
        chk(flags_out === 4'b1001, "R5 ADD overflow NV", {28'd0, flags_out}, 32'b1001);
        run_op(4'd4, 1, 4'd14, 32'hFFFFFFFF, 32'd1, 4'h0, 0, 0, "R5 ADD carry");
        chk(flags_out === 4'b0110, "R5 ADD carry ZC", {28'd0, flags_out}, 32'b0110);
        run_op(4'd5, 1, 4'd14, 32'd10, 32'd20, 4'b0010, 0, 0, "R1 ADC");
        chk(result === 32'd31, "R1 ADC literal", result, 32'd31);
        run_op(4'd2, 1, 4'd14, 32'd5, 32'd7, 4'h0, 0, 0, "R5 SUB borrow");
        chk(flags_out === 4'b1000, "R5 SUB borrow C=0", {28'd0, flags_out}, 32'b1000);
        run_op(4'd2, 1, 4'd14, 32'd7, 32'd5, 4'h0, 0, 0, "R5 SUB no borrow");
        chk(flags_out === 4'b0010, "R5 SUB C=1", {28'd0, flags_out}, 32'b0010);
        run_op(4'd2, 1, 4'd14, 32'h80000000, 32'd1, 4'h0, 0, 0, "R5 SUB overflow");
        run_op(4'd6, 1, 4'd14, 32'd10, 32'd3, 4'b0000, 0, 0, "R1 SBC borrow in");
        chk(result === 32'd6, "R1 SBC literal", result, 32'd6);
        run_op(4'd6, 1, 4'd14, 32'd3, 32'd3, 4'b0000, 0, 0, "R5 SBC wrap");
        run_op(4'd3, 1, 4'd14, 32'd5, 32'd7, 4'h0, 0, 0, "R1 RSB");
        chk(result === 32'd2, "R1 RSB literal", result, 32'd2);
        run_op(4'd7, 0, 4'd14, 32'd5, 32'd7, 4'h0, 0, 0, "R1 RSC");
        chk(result === 32'd1, "R1 RSC literal", result, 32'd1);
        run_op(4'd7, 1, 4'd14, 32'd7, 32'd7, 4'b0010, 0, 0, "R5 RSC equal");
    endtask

    task automatic test_logic();
        run_op(4'd0,  1, 4'd14, 32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0001, 1, 1, "R2 AND");
        run_op(4'd1,  1, 4'd14, 32'hAAAA_5555, 32'hAAAA_5555, 4'b0011, 0, 1, "R6 EOR zero");
        run_op(4'd12, 1, 4'd14, 32'h0000_00F0, 32'h8000_000F, 4'b0010, 0, 0, "R6 ORR keep C");
        run_op(4'd13, 1, 4'd14, 32'h1111_1111, 32'h0000_0000, 4'b1011, 0, 0, "R6 MOV zero");
        run_op(4'd14, 0, 4'd14, 32'hFFFF_FFFF, 32'h0000_FF00, 4'h0, 0, 0, "R2 BIC");
        chk(result === 32'hFFFF_00FF, "R2 BIC literal", result, 32'hFFFF_00FF);
        run_op(4'd15, 1, 4'd14, 32'h0, 32'h0000_00FF, 4'b0001, 1, 1, "R2 MVN");
        chk(flags_out === 4'b1011, "R6 MVN C from shifter, V kept", {28'd0, flags_out}, 32'b1011);
    endtask

    task automatic test_compare();
        run_op(4'd10, 0, 4'd14, 32'd9, 32'd9, 4'h0, 0, 0, "R3 CMP equal");
        chk(flags_out === 4'b0110 && result_we === 1'b0, "R3 CMP flags only",
            {27'd0, result_we, flags_out}, 32'b0110);
        run_op(4'd11, 0, 4'd14, 32'hFFFF_FFFF, 32'd2, 4'h0, 0, 0, "R3 CMN");
        run_op(4'd8,  0, 4'd14, 32'hF0, 32'h0F, 4'b1000, 1, 1, "R3 TST");
        run_op(4'd9,  1, 4'd14, 32'h8000_0000, 32'h1, 4'h0, 0, 0, "R3 TEQ");
    endtask

    task automatic test_s_gate();
        run_op(4'd4, 0, 4'd14, 32'hFFFF_FFFF, 32'd1, 4'b1001, 0, 0, "R4 ADD no S");
        chk(flags_out === 4'b1001 && flags_we === 1'b0, "R4 flags untouched",
            {27'd0, flags_we, flags_out}, 32'b1001);
        run_op(4'd13, 0, 4'd14, 32'd0, 32'd0, 4'b0000, 1, 1, "R4 MOV no S");
    endtask

    task automatic test_conditions();
        logic [3:0] pats [6] = '{4'b0000, 4'b0100, 4'b0010, 4'b1000, 4'b1001, 4'b0110};
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 6; p++) begin
                run_op(4'd4, 1, c[3:0], 32'd3, 32'd4, pats[p], 0, 0,
                       (c == 15) ? "R9 never" : "R7 condition");
                if (!ref_cond(c[3:0], pats[p]))
                    chk(!result_we && !flags_we && flags_out === pats[p],
                        "R8 failed condition no write", {27'd0, result_we, flags_out}, {28'd0, pats[p]});
            end
        end
    endtask

    task automatic test_timing();
        @(negedge clk);
        in_valid = 1'b1; opcode = 4'd4; set_flags = 1'b1; cond = 4'd14;
        op_a = 32'd1; op_b = 32'd2; flags_in = 4'h0;
        @(negedge clk);
        chk(out_valid === 1'b1 && result === 32'd3, "R10 first of pair", result, 32'd3);
        op_a = 32'd100; op_b = 32'd200;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1 && result === 32'd300, "R10 back to back", result, 32'd300);
        @(negedge clk);
        chk(out_valid === 1'b0 && !result_we && !flags_we, "R10 idle after strobe",
            {29'd0, out_valid, result_we, flags_we}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_arith();
        test_logic();
        test_compare();
        test_s_gate();
        test_conditions();
        test_timing();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule